// File: doc/BRIEF.md
# Wake Event Status Aggregator

This block gathers wake-up events from a set of platform sources and folds them into one power-management request pin. The sources are two ring-indicator inputs, keyboard data, mouse data, a parameterized group of general-purpose pins, a watchdog pulse, a parameterized group of device interrupt requests and a fan tachometer event line. Every source is synchronized into the block clock and edge-detected. Each source has a sticky status bit, an individual enable bit, a sense-inversion bit and a both-edges bit.

A small register port gives software read access to the status, enable, inversion, both-edges, control and summary registers. It also gives write access to all of them except the summary. The output pin is asserted when the global enable is on and at least one source has both its status and its enable bit set. Its active level and its drive style (open-drain or push-pull) are programmable. The register port and the source inputs are plain level signals: there is no data stream and no back-pressure. A write takes effect on the clock edge where `reg_wr` is high, and `reg_rdata` shows the register selected by `reg_addr` in the same cycle.

Source bit order in every per-source register, with the default parameters in brackets: bit 0 is `ri_n[0]`, bit 1 is `ri_n[1]`, bit 2 is keyboard data, bit 3 is mouse data. Then come the GPIO pins (4..7), the watchdog pulse (8), the device interrupts (9..12) and the fan event (13). Register addresses: 0 status, 1 enable, 2 inversion, 3 both-edges, 4 control, 5 summary. The control register holds three bits: bit 0 is the global enable, bit 1 selects an active-high pin, and bit 2 selects push-pull drive.

Top module: `wake_event_agg`

## Requirements
- R1: An active edge on a source sets its status bit even while the global enable (control bit 0) is 0. A change sampled at clock edge k sets the bit at edge k+2.
- R2: Writing address 0 clears each status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R3: If a new event for a source and a write-1-to-clear of its bit fall on the same clock edge, the status bit stays set.
- R4: One cycle after a change in the registers, the pin becomes asserted if and only if the global enable is 1 and some source has both its status and its enable bit set.
- R5: The summary register (address 5, bit 0) reads 1 whenever some source has both its status and its enable bit set, whatever the global enable. It reads 0 once no such source remains.
- R6: With the inversion and both-edges bits at 0, the ring inputs, keyboard and mouse (bits 0..3) respond to a high-to-low edge. All other sources respond to a low-to-high edge.
- R7: An inversion bit of 1 swaps the active edge of its source. Changing an inversion bit does not by itself set a status bit.
- R8: A both-edges bit of 1 makes rising and falling edges of that source both set its status bit.
- R9: After reset the pin is active low and open-drain: `pme_pad_o`=1 and `pme_pad_oe`=0 while idle, and `pme_pad_o`=0 and `pme_pad_oe`=1 while asserted. Control bit 1 inverts the level. Control bit 2 keeps `pme_pad_oe`=1 in both states.
- R10: A single transition sets the status bit once. A level held afterwards does not set the bit again after it has been cleared.
- R11: All registers read 0 after reset. The enable, inversion, both-edges and control registers read back the last value written (control in bits 2:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ri_n | input | 2 | Ring-indicator inputs, idle high |
| kbd_data | input | 1 | Keyboard data line, idle high |
| mouse_data | input | 1 | Mouse data line, idle high |
| gpio | input | NGPIO | General-purpose wake pins |
| wdt_pulse | input | 1 | Watchdog expiry pulse |
| dev_irq | input | NIRQ | Device interrupt requests |
| fan_evt | input | 1 | Fan tachometer event |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr |
| pme_pad_o | output | 1 | Pin output level |
| pme_pad_oe | output | 1 | Pin output enable |

## Verification
The hardest case to reach from the ports is a new edge landing on exactly the clock edge where software clears the same status bit. The stimulus first sets the bit with one interrupt rise and drops the line. It then raises the line again and raises the write-1-to-clear strobe two cycles later, which is the synchronizer and edge-detector latency. The status bit must survive the write. Swapping the sense of a source without touching its level is the other subtle path, and the bench reads status back straight after the inversion write to show no event was made.

// File: rtl/wake_pkg.sv
package wake_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT = 3'd0,
    A_EN   = 3'd1,
    A_INV  = 3'd2,
    A_BOTH = 3'd3,
    A_CTRL = 3'd4,
    A_SUM  = 3'd5
  } wake_addr_e;

  typedef struct packed {
    logic push_pull;
    logic act_high;
    logic gen_en;
  } wake_ctrl_t;

  localparam int CTRL_W = $bits(wake_ctrl_t);

endpackage

// File: rtl/wake_edge.sv
module wake_edge #(
  parameter int         N         = 14,
  parameter logic [N-1:0] FALL_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] inv,
  input  logic [N-1:0] both,
  output logic [N-1:0] evt
);

  for (genvar gi = 0; gi < N; gi++) begin : g_src
    logic meta_q, sync_q, prev_q;
    logic rise, fall, s_rise, s_fall;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= raw[gi];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end

    // edges are taken on the raw synchronized level so that a change of
    // the inversion bit alone never looks like a transition
    assign rise   = sync_q & ~prev_q;
    assign fall   = ~sync_q & prev_q;
    assign s_rise = inv[gi] ? fall : rise;
    assign s_fall = inv[gi] ? rise : fall;

    always_comb begin
      if (both[gi])            evt[gi] = rise | fall;
      else if (FALL_MASK[gi])  evt[gi] = s_fall;
      else                     evt[gi] = s_rise;
    end
  end

endmodule

// File: rtl/wake_regs.sv
module wake_regs
  import wake_pkg::*;
#(
  parameter int N  = 14,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic [N-1:0]      evt,
  output logic [DW-1:0]     reg_rdata,
  output logic [N-1:0]      status,
  output logic [N-1:0]      enable,
  output logic [N-1:0]      inv,
  output logic [N-1:0]      both,
  output wake_ctrl_t        ctrl
);

  logic [N-1:0] status_q, enable_q, inv_q, both_q;
  wake_ctrl_t   ctrl_q;
  logic [N-1:0] clr_mask;
  logic         summary;
  logic         unused_wbits;

  assign unused_wbits = ^reg_wdata;

  assign clr_mask = (reg_wr && reg_addr == A_STAT) ? reg_wdata[N-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      inv_q    <= '0;
      both_q   <= '0;
      ctrl_q   <= '0;
    end else begin
      // a fresh event wins over a clear on the same edge
      status_q <= (status_q & ~clr_mask) | evt;
      if (reg_wr) begin
        case (reg_addr)
          A_EN:    enable_q <= reg_wdata[N-1:0];
          A_INV:   inv_q    <= reg_wdata[N-1:0];
          A_BOTH:  both_q   <= reg_wdata[N-1:0];
          A_CTRL:  ctrl_q   <= wake_ctrl_t'(reg_wdata[CTRL_W-1:0]);
          default: ;
        endcase
      end
    end
  end

  assign summary = |(status_q & enable_q);

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = DW'(status_q);
      A_EN:    reg_rdata = DW'(enable_q);
      A_INV:   reg_rdata = DW'(inv_q);
      A_BOTH:  reg_rdata = DW'(both_q);
      A_CTRL:  reg_rdata = DW'(ctrl_q);
      A_SUM:   reg_rdata = DW'(summary);
      default: reg_rdata = '0;
    endcase
  end

  assign status = status_q;
  assign enable = enable_q;
  assign inv    = inv_q;
  assign both   = both_q;
  assign ctrl   = ctrl_q;

endmodule

// File: rtl/wake_pad.sv
module wake_pad
  import wake_pkg::*;
#(
  parameter int N = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] status,
  input  logic [N-1:0] enable,
  input  wake_ctrl_t   ctrl,
  output logic         act,
  output logic         pad_o,
  output logic         pad_oe
);

  logic act_d;

  assign act_d = ctrl.gen_en & (|(status & enable));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= 1'b0;
      pad_o  <= 1'b1;
      pad_oe <= 1'b0;
    end else begin
      act    <= act_d;
      pad_o  <= ctrl.act_high ? act_d : ~act_d;
      pad_oe <= ctrl.push_pull | act_d;
    end
  end

endmodule

// File: rtl/wake_event_agg.sv
module wake_event_agg
  import wake_pkg::*;
#(
  parameter int NGPIO = 4,
  parameter int NIRQ  = 4,
  parameter int DW    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ri_n,
  input  logic              kbd_data,
  input  logic              mouse_data,
  input  logic [NGPIO-1:0]  gpio,
  input  logic              wdt_pulse,
  input  logic [NIRQ-1:0]   dev_irq,
  input  logic              fan_evt,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              pme_pad_o,
  output logic              pme_pad_oe
);

  localparam int N_FIXED = 6;
  localparam int N       = N_FIXED + NGPIO + NIRQ;
  localparam logic [N-1:0] FALL_MASK = N'(4'b1111);

  logic [N-1:0] raw_w, evt_w, status_w, enable_w, inv_w, both_w;
  wake_ctrl_t   ctrl_w;
  logic         ctrl_gen, ctrl_ah, ctrl_pp;
  logic         pme_act;

  assign raw_w = {fan_evt, dev_irq, wdt_pulse, gpio, mouse_data, kbd_data, ri_n};

  assign ctrl_gen = ctrl_w.gen_en;
  assign ctrl_ah  = ctrl_w.act_high;
  assign ctrl_pp  = ctrl_w.push_pull;

  wake_edge #(.N(N), .FALL_MASK(FALL_MASK)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (raw_w),
    .inv  (inv_w),
    .both (both_w),
    .evt  (evt_w)
  );

  wake_regs #(.N(N), .DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .evt      (evt_w),
    .reg_rdata(reg_rdata),
    .status   (status_w),
    .enable   (enable_w),
    .inv      (inv_w),
    .both     (both_w),
    .ctrl     (ctrl_w)
  );

  wake_pad #(.N(N)) u_pad (
    .clk   (clk),
    .rst_n (rst_n),
    .status(status_w),
    .enable(enable_w),
    .ctrl  (ctrl_w),
    .act   (pme_act),
    .pad_o (pme_pad_o),
    .pad_oe(pme_pad_oe)
  );

endmodule

// File: rtl/wake_event_agg_chk.sv
module wake_event_agg_chk #(
  parameter int N  = 14,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [N-1:0]  evt,
  input logic [N-1:0]  status,
  input logic [N-1:0]  enable,
  input logic          gen,
  input logic          ah,
  input logic          pp,
  input logic          act,
  input logic          pad_o,
  input logic          pad_oe
);

  // R1: detected events land in status regardless of the global enable
  p_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((status & $past(evt)) == $past(evt)));

  // R2: write-1-to-clear with no competing event
  p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && evt == '0)
      |=> (status == ($past(status) & ~$past(reg_wdata[N-1:0]))));

  // R3: event and clear on the same edge leave the bit set
  p_evt_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && |(evt & reg_wdata[N-1:0]))
      |=> ((status & $past(evt)) == $past(evt)));

  // R4: request follows gated status and enable one cycle later
  p_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (act == $past(gen && |(status & enable))));

  // R9: open-drain drives only while asserting
  p_od_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ($past(pp) || (pad_oe == act)));

  // R9: pin level follows the programmed polarity
  p_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (pad_o == ($past(ah) ? act : !act)));

endmodule

bind wake_event_agg wake_event_agg_chk #(.N(N), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .evt      (evt_w),
  .status   (status_w),
  .enable   (enable_w),
  .gen      (ctrl_gen),
  .ah       (ctrl_ah),
  .pp       (ctrl_pp),
  .act      (pme_act),
  .pad_o    (pme_pad_o),
  .pad_oe   (pme_pad_oe)
);

// File: tb/wake_event_agg_test.sv
`timescale 1ns/1ps
module wake_event_agg_test;

  localparam int NG = 4;
  localparam int NI = 4;
  localparam int DW = 16;
  localparam int NS = 6 + NG + NI;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    ri_n = 2'b11;
  logic          kbd_data = 1'b1;
  logic          mouse_data = 1'b1;
  logic [NG-1:0] gpio = '0;
  logic          wdt_pulse = 1'b0;
  logic [NI-1:0] dev_irq = '0;
  logic          fan_evt = 1'b0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = 3'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          pme_pad_o, pme_pad_oe;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  wake_event_agg #(.NGPIO(NG), .NIRQ(NI), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .ri_n(ri_n), .kbd_data(kbd_data),
    .mouse_data(mouse_data), .gpio(gpio), .wdt_pulse(wdt_pulse),
    .dev_irq(dev_irq), .fan_evt(fan_evt), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pme_pad_o(pme_pad_o), .pme_pad_oe(pme_pad_oe)
  );

  // ---------------- behavioural reference ----------------
  logic [NS-1:0] h1, h2, h3, m_stat, m_en, m_inv, m_both;
  logic [2:0]    m_ctrl;
  logic          m_o, m_oe;

  function automatic logic [DW-1:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return DW'(m_stat);
      3'd1: return DW'(m_en);
      3'd2: return DW'(m_inv);
      3'd3: return DW'(m_both);
      3'd4: return DW'(m_ctrl);
      3'd5: return DW'(|(m_stat & m_en));
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      h1 = '0; h2 = '0; h3 = '0;
      m_stat = '0; m_en = '0; m_inv = '0; m_both = '0; m_ctrl = '0;
      m_o = 1'b1; m_oe = 1'b0;
    end else begin
      logic [NS-1:0] ev, clr, raw;
      logic a;
      for (int i = 0; i < NS; i++) begin
        logic r, f;
        r = h2[i] & ~h3[i];
        f = ~h2[i] & h3[i];
        if (m_both[i]) ev[i] = r | f;
        else if (i < 4) ev[i] = m_inv[i] ? r : f;
        else ev[i] = m_inv[i] ? f : r;
      end
      a = m_ctrl[0] && (|(m_stat & m_en));
      m_o  = m_ctrl[1] ? a : !a;
      m_oe = m_ctrl[2] | a;
      clr = (reg_wr && reg_addr == 3'd0) ? reg_wdata[NS-1:0] : '0;
      m_stat = (m_stat & ~clr) | ev;
      if (reg_wr) begin
        if (reg_addr == 3'd1) m_en   = reg_wdata[NS-1:0];
        if (reg_addr == 3'd2) m_inv  = reg_wdata[NS-1:0];
        if (reg_addr == 3'd3) m_both = reg_wdata[NS-1:0];
        if (reg_addr == 3'd4) m_ctrl = reg_wdata[2:0];
      end
      raw = {fan_evt, dev_irq, wdt_pulse, gpio, mouse_data, kbd_data, ri_n};
      h3 = h2; h2 = h1; h1 = raw;
    end
  end

  // every-clock comparison of pin and read port against the reference
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      n_cmp++;
      if (pme_pad_o !== m_o || pme_pad_oe !== m_oe) begin
        n_bad++;
        $display("FAIL model R4 pin o/oe got %b%b expected %b%b", pme_pad_o, pme_pad_oe, m_o, m_oe);
      end
      n_cmp++;
      if (reg_rdata !== m_read(reg_addr)) begin
        n_bad++;
        $display("FAIL model R11 rdata@%0d got %h expected %h", reg_addr, reg_rdata, m_read(reg_addr));
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pin(input logic eo, input logic eoe, input string tag);
    @(negedge clk);
    #1;
    chk(tag, DW'({pme_pad_o, pme_pad_oe}), DW'({eo, eoe}));
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R11 reset values, R9 idle pin
    for (int a = 0; a < 6; a++) rd(3'(a), '0, "R11 reset value");
    pin(1'b1, 1'b0, "R9 reset idle pin");

    // R1 / R6: gpio0 rising with global enable off
    @(negedge clk); gpio[0] = 1'b1;
    settle();
    rd(3'd0, 16'h0010, "R1 status set with global off");
    pin(1'b1, 1'b0, "R4 no request while global off");

    // R4 / R9 assert active low open-drain
    wr(3'd1, 16'h0010);
    wr(3'd4, 16'h0001);
    settle();
    pin(1'b0, 1'b1, "R9 asserted active low OD");
    rd(3'd5, 16'h0001, "R5 summary set");
    rd(3'd1, 16'h0010, "R11 enable readback");

    // R2 write zero then write one
    wr(3'd0, 16'h0000);
    rd(3'd0, 16'h0010, "R2 write zero keeps");
    wr(3'd0, 16'h0010);
    settle();
    rd(3'd0, 16'h0000, "R2 write one clears");
    pin(1'b1, 1'b0, "R4 released after clear");
    settle();
    rd(3'd0, 16'h0000, "R10 held level no re-set");

    // R6 default edges
    @(negedge clk); ri_n[0] = 1'b0; kbd_data = 1'b0; gpio[0] = 1'b0;
    @(negedge clk); wdt_pulse = 1'b1; fan_evt = 1'b1;
    @(negedge clk); wdt_pulse = 1'b0; fan_evt = 1'b0;
    settle();
    rd(3'd0, 16'h2105, "R6 default edge senses");
    wr(3'd0, 16'hFFFF);
    @(negedge clk); ri_n[0] = 1'b1;
    settle();
    rd(3'd0, 16'h0000, "R6 ring rise ignored");

    // R7 inversion
    wr(3'd2, 16'h0024);
    settle();
    rd(3'd0, 16'h0000, "R7 inversion write no event");
    rd(3'd2, 16'h0024, "R11 inversion readback");
    @(negedge clk); gpio[1] = 1'b1;
    settle();
    rd(3'd0, 16'h0000, "R7 inverted gpio rise ignored");
    @(negedge clk); gpio[1] = 1'b0; kbd_data = 1'b1;
    settle();
    rd(3'd0, 16'h0024, "R7 inverted edges set");
    wr(3'd0, 16'hFFFF);

    // R8 both edges on mouse
    wr(3'd3, 16'h0008);
    @(negedge clk); mouse_data = 1'b0;
    settle();
    rd(3'd0, 16'h0008, "R8 falling edge");
    wr(3'd0, 16'h0008);
    @(negedge clk); mouse_data = 1'b1;
    settle();
    rd(3'd0, 16'h0008, "R8 rising edge");
    wr(3'd0, 16'h0008);

    // R3 event on the clearing edge
    @(negedge clk); dev_irq[0] = 1'b1;
    settle();
    @(negedge clk); dev_irq[0] = 1'b0;
    settle();
    rd(3'd0, 16'h0200, "R3 bit preset");
    @(negedge clk); dev_irq[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 16'h0200;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    rd(3'd0, 16'h0200, "R3 event beats clear");
    wr(3'd0, 16'h0200);
    rd(3'd0, 16'h0000, "R3 later clear works");

    // R5 summary independent of global enable
    @(negedge clk); dev_irq[0] = 1'b0;
    @(negedge clk); dev_irq[1] = 1'b1;
    wr(3'd1, 16'h0400);
    wr(3'd4, 16'h0000);
    settle();
    rd(3'd5, 16'h0001, "R5 summary with global off");
    pin(1'b1, 1'b0, "R4 global off no request");

    // R9 active high push-pull
    wr(3'd4, 16'h0007);
    settle();
    rd(3'd4, 16'h0007, "R11 control readback");
    pin(1'b1, 1'b1, "R9 active high asserted");
    wr(3'd1, 16'h0000);
    settle();
    rd(3'd5, 16'h0000, "R5 summary clears");
    pin(1'b0, 1'b1, "R9 push-pull idle driven");
    wr(3'd4, 16'h0003);
    settle();
    pin(1'b0, 1'b0, "R9 active high OD idle");
    wr(3'd1, 16'h0400);
    settle();
    pin(1'b1, 1'b1, "R9 active high OD asserted");

    settle();
    finish_run();
  end

endmodule